// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

A compact timer peripheral holding a parameterised number of independent down-counting channels behind a simple single-cycle register bus. Each channel has a reload value, a live count and a control word. The control word picks one of several prescaled count rates and enables an interrupt. The run bits for all channels sit together in one shared byte register, so software can start or stop any set of channels with one write.

On every prescaled tick a running channel's count drops by one. The tick after the count reaches zero reloads the count from the reload value and raises a sticky underflow flag. The flag drives a level interrupt when it is enabled, and software clears it by writing a zero into the flag position. Loading both reload and count with all ones gives a free-running counter; the ticks elapsed since the start are the count XORed with all ones. A reload value of N gives a periodic event every N+1 ticks.

Top module: `mtimer_bank`

## Requirements
- R1: After reset every run bit is 0, every control word reads 0x0000, every reload and count register reads 0xFFFFFFFF and every interrupt output is low.
- R2: The shared run register is at word address 0, and its bit c runs channel c. Bits at or above the channel count read 0 whatever is written to them. A halted channel's count holds its value.
- R3: A running channel decrements once per prescaled tick. Control bits [2:0] choose the rate: 0 gives the clock divided by 4, 1 gives /16, 2 gives /64, 3 gives /256 and 4 gives /1024. Codes 5 to 7 act as /4.
- R4: A tick that finds the count at 0 loads the count from the reload register instead of decrementing. A reload value of N therefore repeats the count sequence every N+1 ticks.
- R5: The underflow flag is control bit 8. It is set on the reloading tick and stays set until a control write carries 0 in bit 8. A control write with 1 in bit 8 has no effect on the flag.
- R6: A channel's interrupt output is high exactly while its flag is set and its control bit 5 (interrupt enable) is 1.
- R7: If a bus write to the count register lands on the same clock as a count tick, the count takes the written value and the tick is dropped.
- R8: If a flag-clearing control write lands on the same clock as an underflow, the flag ends up set.
- R9: With reload and count at 0xFFFFFFFF, the count XORed with 0xFFFFFFFF equals the number of ticks since the run bit was set.
- R10: Reload and count may be written while a channel is halted. Counting resumes from the written count, and the first decrement comes on the first tick after the clock edge that sets the run bit.
- R11: Channel c uses word addresses 4+4c (reload), 4+4c+1 (count) and 4+4c+2 (control). The control word reads back bits [2:0], 5 and 8, and all its other bits read 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not selected |
| irq_o | output | NUM_CH | Per-channel level interrupt |

## Verification
Two pairs of functions can fall in the same clock. A bus write to the count can meet a count tick, and a flag-clearing control write can meet the underflow it would clear. The bench finds the tick phase by polling the count until it changes. It then knows the divide-by-4 tick repeats four clocks later, so it lands the count write exactly on a tick and then a flag clear exactly on the following underflow. The outcomes are judged at the ports: the count must equal the written value rather than one less, and the flag and interrupt must still be set while the count shows the reload value.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

   localparam int PSC_W      = 3;
   localparam int RUN_W      = 8;
   localparam int CTRL_W     = 16;
   localparam int BIT_IE     = 5;
   localparam int BIT_FLAG   = 8;
   localparam int STEP_BITS  = 2;

   typedef enum logic [1:0] {
      SLOT_RELOAD = 2'd0,
      SLOT_COUNT  = 2'd1,
      SLOT_CTRL   = 2'd2,
      SLOT_NONE   = 2'd3
   } chan_slot_e;

   typedef struct packed {
      logic             flag;
      logic             ie;
      logic [PSC_W-1:0] psc;
   } chan_ctrl_t;

   function automatic logic [CTRL_W-1:0] pack_ctrl(input chan_ctrl_t c);
      logic [CTRL_W-1:0] w;
      w              = '0;
      w[PSC_W-1:0]   = c.psc;
      w[BIT_IE]      = c.ie;
      w[BIT_FLAG]    = c.flag;
      return w;
   endfunction

endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
   parameter int STAGES    = 5,
   parameter int STEP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [STAGES-1:0] tick_o
);
   localparam int DIV_W = STEP_BITS * STAGES;

   if (STAGES < 1 || STEP_BITS < 1) begin : g_bad_cfg
      $error("mtimer_prescaler: STAGES and STEP_BITS must be positive");
   end

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_tap
      assign tick_o[k] = &div_q[STEP_BITS*(k+1)-1:0];
   end

   // the fastest tick is never high on two clocks in a row
   assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[0] |=> !tick_o[0]);

endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel
   import mtimer_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int STAGES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [STAGES-1:0] tick_i,
   input  logic              rld_we,
   input  logic              cnt_we,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  rld_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CTRL_W-1:0] ctl_o,
   output logic              irq_o
);
   if (DATA_W < CNT_W || DATA_W < CTRL_W) begin : g_bad_width
      $error("mtimer_channel: DATA_W must cover count and control widths");
   end
   if (STAGES > (1 << PSC_W)) begin : g_bad_stages
      $error("mtimer_channel: too many prescale stages for the select field");
   end

   logic [CNT_W-1:0] rld_q, cnt_q;
   chan_ctrl_t       ctl_q;
   logic             tick_sel, count_en, at_zero, uflow;

   always_comb begin
      tick_sel = tick_i[0];
      for (int k = 1; k < STAGES; k++) begin
         if (ctl_q.psc == PSC_W'(k)) tick_sel = tick_i[k];
      end
   end

   assign count_en = run_i && tick_sel;
   assign at_zero  = (cnt_q == '0);
   assign uflow    = count_en && at_zero && !cnt_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q <= '1;
      end else if (rld_we) begin
         rld_q <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
      end else if (cnt_we) begin
         cnt_q <= wdata[CNT_W-1:0];
      end else if (count_en) begin
         cnt_q <= at_zero ? rld_q : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (ctl_we) begin
            ctl_q.psc <= wdata[PSC_W-1:0];
            ctl_q.ie  <= wdata[BIT_IE];
         end
         if (uflow) begin
            ctl_q.flag <= 1'b1;
         end else if (ctl_we && !wdata[BIT_FLAG]) begin
            ctl_q.flag <= 1'b0;
         end
      end
   end

   assign rld_o = rld_q;
   assign cnt_o = cnt_q;
   assign ctl_o = pack_ctrl(ctl_q);
   assign irq_o = ctl_q.flag && ctl_q.ie;

   assert_hold_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !cnt_we) |=> $stable(cnt_o));

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && at_zero && !cnt_we && !rld_we) |=> (cnt_o == $past(rld_o)));

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[BIT_FLAG] && !(ctl_we && !wdata[BIT_FLAG])) |=> ctl_o[BIT_FLAG]);

   assert_irq_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !wdata[BIT_FLAG] && !uflow) |=> !irq_o);

   assert_bus_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_o == $past(wdata[CNT_W-1:0])));

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> ctl_o[BIT_FLAG]);

endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
   import mtimer_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   parameter int STAGES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int GRP_W = ADDR_W - 2;
   localparam logic [RUN_W-1:0] RUN_MASK = RUN_W'((1 << NUM_CH) - 1);

   if (NUM_CH < 1 || NUM_CH > RUN_W) begin : g_bad_nch
      $error("mtimer_bank: NUM_CH must lie in 1..8");
   end
   if ((NUM_CH + 1) * 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("mtimer_bank: ADDR_W too narrow for the channel count");
   end
   if (DATA_W < RUN_W) begin : g_bad_data
      $error("mtimer_bank: DATA_W narrower than the run register");
   end

   logic [STAGES-1:0] tick;
   logic [RUN_W-1:0]  run_q;
   logic              wr_en, run_hit;
   logic [GRP_W-1:0]  grp;
   chan_slot_e        slot;

   logic [CNT_W-1:0]  rld_v [NUM_CH];
   logic [CNT_W-1:0]  cnt_v [NUM_CH];
   logic [CTRL_W-1:0] ctl_v [NUM_CH];

   assign wr_en   = bus_sel && bus_wr;
   assign grp     = bus_addr[ADDR_W-1:2];
   assign slot    = chan_slot_e'(bus_addr[1:0]);
   assign run_hit = (bus_addr == '0);

   mtimer_prescaler #(.STAGES(STAGES), .STEP_BITS(STEP_BITS)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_q <= '0;
      else if (wr_en && run_hit) run_q <= bus_wdata[RUN_W-1:0] & RUN_MASK;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = (grp == GRP_W'(c + 1));

      mtimer_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_i  (run_q[c]),
         .tick_i (tick),
         .rld_we (wr_en && hit && slot == SLOT_RELOAD),
         .cnt_we (wr_en && hit && slot == SLOT_COUNT),
         .ctl_we (wr_en && hit && slot == SLOT_CTRL),
         .wdata  (bus_wdata),
         .rld_o  (rld_v[c]),
         .cnt_o  (cnt_v[c]),
         .ctl_o  (ctl_v[c]),
         .irq_o  (irq_o[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (run_hit) begin
            bus_rdata[RUN_W-1:0] = run_q;
         end
         for (int c = 0; c < NUM_CH; c++) begin
            if (grp == GRP_W'(c + 1)) begin
               case (slot)
                  SLOT_RELOAD: bus_rdata[CNT_W-1:0]  = rld_v[c];
                  SLOT_COUNT:  bus_rdata[CNT_W-1:0]  = cnt_v[c];
                  SLOT_CTRL:   bus_rdata[CTRL_W-1:0] = ctl_v[c];
                  default:     bus_rdata = '0;
               endcase
            end
         end
      end
   end

   assert_run_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && run_hit) |=> ((run_q & ~RUN_MASK) == '0));

endmodule

// File: tb/mtimer_bank_test.sv
`timescale 1ns/1ps
module mtimer_bank_test;
   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mtimer_bank #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   function automatic logic [5:0] ra(input int c, input int off);
      return 6'(4 + 4*c + off);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // caller stands at a negedge; the write is taken at the next posedge
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #0.5;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v0, v1;
      logic [31:0] o0, o1;
      int divs [8];
      divs = '{4, 16, 64, 256, 1024, 4, 4, 4};

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(6'd0, v); check("R1 run", v, 32'h0);
      for (int c = 0; c < NCH; c++) begin
         rd(ra(c,0), v); check("R1 reload", v, 32'hFFFF_FFFF);
         rd(ra(c,1), v); check("R1 count", v, 32'hFFFF_FFFF);
         rd(ra(c,2), v); check("R1 ctrl", v, 32'h0);
      end
      check("R1 irq", 32'(irq_o), 32'h0);

      // R11 address map holes, R2 run mask
      rd(6'h3F, v); check("R11 unmapped", v, 32'h0);
      rd(ra(0,3), v); check("R11 slot3", v, 32'h0);
      wr(6'd0, 32'hFF); rd(6'd0, v); check("R2 run mask", v, 32'h07);
      wr(6'd0, 32'h00);
      wr(ra(0,1), 32'hFFFF_FFFF); wr(ra(1,1), 32'hFFFF_FFFF); wr(ra(2,1), 32'hFFFF_FFFF);

      // R9 free-running elapsed count on channel 0
      wr(6'd0, 32'h01);
      rd(ra(0,1), v); check("R9 elapsed at start", v ^ 32'hFFFF_FFFF, 32'd0);
      idle(40);
      rd(ra(0,1), v); check("R9 elapsed after 40 clocks", v ^ 32'hFFFF_FFFF, 32'd10);

      // R7, R8, R4 coincidences on channel 0 (still running, divide by 4)
      wr(ra(0,0), 32'h40);
      wr(ra(0,2), 32'h20);
      rd(ra(0,1), v0);
      for (int i = 0; i < 8; i++) begin
         idle(1); rd(ra(0,1), v1);
         if (v1 != v0) break;
         v0 = v1;
      end
      idle(3);
      wr(ra(0,1), 32'h0);                  // lands on a tick edge
      rd(ra(0,1), v); check("R7 write beats tick", v, 32'h0);
      idle(3);
      wr(ra(0,2), 32'h20);                 // flag clear on the underflow edge
      rd(ra(0,1), v); check("R4 reload on underflow", v, 32'h40);
      rd(ra(0,2), v); check("R8 set beats clear", v, 32'h120);
      check("R6 irq with flag and enable", 32'(irq_o[0]), 32'h1);
      wr(6'd0, 32'h00);
      wr(ra(0,2), 32'h20);
      rd(ra(0,2), v); check("R5 flag cleared", v, 32'h20);
      check("R6 irq drops", 32'(irq_o[0]), 32'h0);
      wr(ra(0,2), 32'h120);
      rd(ra(0,2), v); check("R5 write one ignored", v, 32'h20);
      check("R5 irq stays low", 32'(irq_o[0]), 32'h0);

      // R4 period and R6 with interrupt disabled, channel 1
      wr(ra(1,0), 32'd5); wr(ra(1,1), 32'd5); wr(ra(1,2), 32'h0);
      wr(6'd0, 32'h02);
      idle(5);
      rd(ra(1,1), v0);
      idle(24);
      rd(ra(1,1), v1); check("R4 period N+1 ticks", v1, v0);
      rd(ra(1,2), v); check("R5 flag set after underflow", v, 32'h100);
      check("R6 irq masked", 32'(irq_o[1]), 32'h0);
      idle(30);
      rd(ra(1,2), v); check("R5 flag sticky", v, 32'h100);
      wr(6'd0, 32'h00);
      wr(ra(1,2), 32'h0);

      // R10 halted load then resume, channel 2; R2 halted hold
      wr(ra(2,1), 32'h1234); wr(ra(2,2), 32'h0);
      idle(50);
      rd(ra(2,1), v); check("R2 halted hold", v, 32'h1234);
      wr(6'd0, 32'h04);
      rd(ra(2,1), v); check("R10 resume value", v, 32'h1234);
      idle(40);
      rd(ra(2,1), v); check("R10 ticks after start", v, 32'h1234 - 32'd10);
      wr(6'd0, 32'h00);

      // R3 prescale sweep on every channel; others must hold (R2)
      for (int c = 0; c < NCH; c++) begin
         for (int p = 0; p < 8; p++) begin
            wr(ra(c,1), 32'h0010_0000);
            wr(ra(c,2), 32'(p));
            wr(6'd0, 32'(1 << c));
            idle(2);
            rd(ra(c,1), v0);
            rd(ra((c+1)%NCH,1), o0);
            idle(3 * divs[p]);
            rd(ra(c,1), v1);
            rd(ra((c+1)%NCH,1), o1);
            check($sformatf("R3 ch%0d code%0d", c, p), v0 - v1, 32'd3);
            check("R2 other channel halted", o1, o0);
            wr(6'd0, 32'h00);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule